// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Counter

This block is a synchronous binary counter built from identical slices of a few bits each. Every slice can count up or down, can be preset from parallel data, and produces an active-low terminal-carry output. All flip-flops share one rising clock edge, so every output bit changes on the same edge and shows no ripple glitches.

Two active-low enables control counting. A slice counts only when both are low. The shared enable goes to every slice. The chain enable goes only to the lowest slice, and each higher slice takes the carry output of the slice below it as its chain enable.

Counting in a slice stops while its carry is inactive, so a carry moves through the whole chain within one clock cycle and no extra gating is needed. A synchronous active-low load has priority over counting. The top-level carry can be fed back into the load input to build a modulo counter. An active-high synchronous reset clears the count to zero.

Top module: `cnt_chain`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count becomes zero after that edge.
- R2: When `load_n` is low at a rising edge, `count_out` equals the `data_in` value from that edge afterwards. This holds for any value of `cnt_en_n`, `chain_en_n` and `dir_up`, so load takes priority over counting.
- R3: With `load_n` high, the count changes at an edge only when `cnt_en_n` and `chain_en_n` are both low. If either enable is high, the count holds.
- R4: When counting, `dir_up` = 1 adds one and `dir_up` = 0 subtracts one, modulo 2^(NUM_STAGES*STAGE_W). All-ones wraps to zero going up, and zero wraps to all-ones going down.
- R5: `carry_n` is high whenever `chain_en_n` is high.
- R6: While `chain_en_n` is low, `carry_n` is low exactly when the count is all ones with `dir_up` = 1, or the count is zero with `dir_up` = 0. It follows these inputs within the same cycle, with no register in between.
- R7: Slices chain through their carries, so the whole counter steps as one wide binary value. A borrow or carry across a slice boundary happens in a single edge, for example 0x0F to 0x10 going up and 0x10 to 0x0F going down.
- R8: If `carry_n` drives `load_n` while counting up from a preset P, the count runs P, P+1, …, all ones and then returns to P. The cycle length is 2^W − P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to zero, active high |
| load_n | input | 1 | Synchronous parallel load, active low |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| cnt_en_n | input | 1 | Shared count enable, active low |
| chain_en_n | input | 1 | Chain count enable of the lowest slice, also gates the carry, active low |
| data_in | input | NUM_STAGES*STAGE_W | Preset value |
| count_out | output | NUM_STAGES*STAGE_W | Current count |
| carry_n | output | 1 | Terminal carry of the top slice, active low |

## Verification
The counter is run through the following sequences:
- A preset just below a slice boundary, counted up. This checks the carry between slices.
- A short count down through zero. This checks the borrow across slices and the wrap to all ones.
- Holds with each enable raised on its own. These show which enable blocks counting and which one also forces the carry high.
- Loads issued while both enables are low and the direction changes. These show that load wins over counting.
- A feedback run with the carry tied to the load input. This checks the modulo cycle length.
- A long run of random inputs and a reset in mid-count. These mix all of the above.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_LOAD = 2'd1,
      OP_INC  = 2'd2,
      OP_DEC  = 2'd3
   } cnt_op_e;

   function automatic cnt_op_e decode_op(input logic load_n,
                                         input logic en_a_n,
                                         input logic en_b_n,
                                         input logic up);
      if (!load_n)
         return OP_LOAD;
      else if (!en_a_n && !en_b_n)
         return up ? OP_INC : OP_DEC;
      else
         return OP_HOLD;
   endfunction

endpackage

// File: rtl/cnt_next_state.sv
module cnt_next_state
   import cnt_pkg::*;
#(
   parameter int SLICE_W = 4
) (
   input  cnt_op_e             op,
   input  logic [SLICE_W-1:0]  cur,
   input  logic [SLICE_W-1:0]  preset,
   output logic [SLICE_W-1:0]  nxt
);
   localparam logic [SLICE_W-1:0] ONE = SLICE_W'(1);

   always_comb begin
      unique case (op)
         OP_LOAD: nxt = preset;
         OP_INC:  nxt = cur + ONE;
         OP_DEC:  nxt = cur - ONE;
         default: nxt = cur;
      endcase
   end
endmodule

// File: rtl/cnt_term_detect.sv
module cnt_term_detect #(
   parameter int SLICE_W = 4
) (
   input  logic [SLICE_W-1:0] value,
   input  logic               up,
   input  logic               gate_n,
   output logic               term_n
);
   logic at_top;
   logic at_bottom;
   logic hit;

   always_comb begin
      at_top    = &value;
      at_bottom = ~|value;
      hit       = up ? at_top : at_bottom;
      term_n    = gate_n | ~hit;
   end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
   import cnt_pkg::*;
#(
   parameter int SLICE_W = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load_n,
   input  logic               up,
   input  logic               en_shared_n,
   input  logic               en_chain_n,
   input  logic [SLICE_W-1:0] preset,
   output logic [SLICE_W-1:0] q,
   output logic               term_n
);
   cnt_op_e            op;
   logic [SLICE_W-1:0] q_next;

   assign op = decode_op(load_n, en_shared_n, en_chain_n, up);

   cnt_next_state #(.SLICE_W(SLICE_W)) u_next (
      .op     (op),
      .cur    (q),
      .preset (preset),
      .nxt    (q_next)
   );

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else
         q <= q_next;
   end

   cnt_term_detect #(.SLICE_W(SLICE_W)) u_term (
      .value  (q),
      .up     (up),
      .gate_n (en_chain_n),
      .term_n (term_n)
   );
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
   parameter int NUM_STAGES = 2,
   parameter int STAGE_W    = 4
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            load_n,
   input  logic                            dir_up,
   input  logic                            cnt_en_n,
   input  logic                            chain_en_n,
   input  logic [NUM_STAGES*STAGE_W-1:0]   data_in,
   output logic [NUM_STAGES*STAGE_W-1:0]   count_out,
   output logic                            carry_n
);
   localparam int CNT_W = NUM_STAGES * STAGE_W;

   generate
      if (NUM_STAGES < 1) begin : g_bad_stages
         $error("cnt_chain: NUM_STAGES must be at least 1");
      end
      if (STAGE_W < 1) begin : g_bad_width
         $error("cnt_chain: STAGE_W must be at least 1");
      end
   endgenerate

   logic [NUM_STAGES:0] link_n;

   assign link_n[0] = chain_en_n;

   for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
      cnt_stage #(.SLICE_W(STAGE_W)) u_stage (
         .clk         (clk),
         .rst         (rst),
         .load_n      (load_n),
         .up          (dir_up),
         .en_shared_n (cnt_en_n),
         .en_chain_n  (link_n[k]),
         .preset      (data_in[k*STAGE_W +: STAGE_W]),
         .q           (count_out[k*STAGE_W +: STAGE_W]),
         .term_n      (link_n[k+1])
      );
   end

   assign carry_n = link_n[NUM_STAGES];
endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             load_n,
   input logic             dir_up,
   input logic             cnt_en_n,
   input logic             chain_en_n,
   input logic [CNT_W-1:0] data_in,
   input logic [CNT_W-1:0] count_out,
   input logic             carry_n
);
   localparam logic [CNT_W-1:0] ALL_ONES = '1;
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> count_out == '0); // R1

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
      !load_n |=> count_out == $past(data_in)); // R2

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (load_n && (cnt_en_n || chain_en_n)) |=> $stable(count_out)); // R3

   AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
      (load_n && !cnt_en_n && !chain_en_n && dir_up)
         |=> count_out == $past(count_out) + ONE); // R4

   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
      (load_n && !cnt_en_n && !chain_en_n && !dir_up)
         |=> count_out == $past(count_out) - ONE); // R4

   AST_CARRY_GATED: assert property (@(posedge clk) disable iff (rst)
      chain_en_n |-> carry_n); // R5

   AST_CARRY_TERMINAL: assert property (@(posedge clk) disable iff (rst)
      !chain_en_n |-> (carry_n == !(dir_up ? (count_out == ALL_ONES)
                                           : (count_out == '0)))); // R6
endmodule

bind cnt_chain cnt_chain_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .load_n     (load_n),
   .dir_up     (dir_up),
   .cnt_en_n   (cnt_en_n),
   .chain_en_n (chain_en_n),
   .data_in    (data_in),
   .count_out  (count_out),
   .carry_n    (carry_n)
);

// File: tb/tb_cnt_chain.sv
`timescale 1ns/1ps
module tb_cnt_chain;
   localparam int NS = 2;
   localparam int SW = 4;
   localparam int W  = NS * SW;
   localparam int MOD = 1 << W;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         load_reg = 1'b1;
   logic         loop_mode = 1'b0;
   logic         dir_up = 1'b1;
   logic         cnt_en_n = 1'b1;
   logic         chain_en_n = 1'b1;
   logic [W-1:0] data_in = '0;
   logic [W-1:0] count_out;
   logic         carry_n;
   logic         load_n;

   int checks = 0;
   int fails  = 0;
   int ref_cnt = 0;
   int prev_cnt = 0;
   string tag = "R1";
   bit done = 1'b0;
   int cyc = 0;

   always #5 clk = ~clk;

   assign load_n = loop_mode ? carry_n : load_reg;

   cnt_chain #(.NUM_STAGES(NS), .STAGE_W(SW)) dut (
      .clk(clk), .rst(rst), .load_n(load_n), .dir_up(dir_up),
      .cnt_en_n(cnt_en_n), .chain_en_n(chain_en_n),
      .data_in(data_in), .count_out(count_out), .carry_n(carry_n)
   );

   // behavioural reference, updated at each rising edge
   always @(posedge clk) begin
      prev_cnt = ref_cnt;
      if (rst) begin
         ref_cnt = 0; tag = "R1";
      end else if (!load_n) begin
         ref_cnt = int'(data_in); tag = loop_mode ? "R8" : "R2";
      end else if (!cnt_en_n && !chain_en_n) begin
         ref_cnt = dir_up ? (ref_cnt + 1) % MOD : (ref_cnt + MOD - 1) % MOD;
         tag = ((ref_cnt / (1 << SW)) != (prev_cnt / (1 << SW))) ? "R7" : "R4";
      end else begin
         tag = "R3";
      end
   end

   function automatic bit exp_carry_n();
      if (chain_en_n) return 1'b1;
      if (dir_up) return !(ref_cnt == MOD - 1);
      return !(ref_cnt == 0);
   endfunction

   always @(posedge clk) begin
      #3;
      if (!done) begin
         checks++;
         if (int'(count_out) != ref_cnt) begin
            fails++;
            $display("FAIL %s count: actual %0h expected %0h", tag, count_out, ref_cnt);
         end
         checks++;
         if (carry_n !== exp_carry_n()) begin
            fails++;
            $display("FAIL %s carry_n: actual %0b expected %0b",
                     chain_en_n ? "R5" : "R6", carry_n, exp_carry_n());
         end
      end
   end

   task automatic drive(input bit ld_n, input int d, input bit up,
                        input bit ep_n, input bit et_n, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         load_reg = ld_n; data_in = W'(d); dir_up = up;
         cnt_en_n = ep_n; chain_en_n = et_n;
      end
   endtask

   initial begin
      drive(1, 8'h5A, 1, 0, 0, 3);           // R1 reset holds zero
      @(negedge clk); rst = 1'b0;
      drive(0, 8'h0D, 1, 0, 0, 1);           // R2 preset
      drive(1, 0, 1, 0, 0, 6);               // R4 / R7 up across 0x0F
      drive(1, 0, 1, 1, 0, 4);               // R3 shared enable blocks
      drive(1, 0, 1, 0, 1, 4);               // R3 / R5 chain enable blocks
      drive(0, 8'hFD, 1, 0, 0, 1);
      drive(1, 0, 1, 0, 0, 5);               // R6 at all ones, R4 wrap
      drive(0, 8'h12, 0, 0, 0, 1);
      drive(1, 0, 0, 0, 0, 5);               // R7 down across 0x10
      drive(0, 8'h02, 0, 0, 0, 1);
      drive(1, 0, 0, 0, 0, 5);               // R6 at zero, R4 wrap down
      drive(0, 8'h33, 1, 0, 0, 1);           // R2 load beats count
      drive(0, 8'hC4, 0, 1, 1, 1);
      drive(0, 8'h00, 0, 0, 1, 1);
      drive(0, 8'hF0, 1, 0, 0, 1);
      @(negedge clk); loop_mode = 1'b1;      // R8 modulo-16 loop
      drive(1, 8'hF0, 1, 0, 0, 40);
      @(negedge clk); loop_mode = 1'b0;
      for (int i = 0; i < 400; i++) begin
         drive(($urandom % 8) != 0, $urandom, $urandom, ($urandom % 4) == 0,
               ($urandom % 5) == 0, 1);
         if (i == 200) begin @(negedge clk); rst = 1'b1; end
         if (i == 202) begin @(negedge clk); rst = 1'b0; end
      end
      @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule